// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Generator

The block turns a group of digitized calorimeter channels into coarse energy primitives for the level-1 trigger. On every sample clock, each channel's current sample has a copy of the same channel taken a programmable number of clocks earlier subtracted from it. This gives a pulse height that follows a slowly moving baseline. A negative height is replaced by zero. The upper bits of the height address a lookup memory that turns it into a 10-bit energy. The memory is shared by all channels and is loaded through a configuration write port.

Four neighbouring channels form a 2x2 tower. The tower sum is 12 bits wide, and its top 8 bits are the primitive. A free-running sub-period counter divides the beam period into 12 sample clocks. At the sub-period chosen by a phase setting, the block snapshots all tower primitives. It then emits a header word, followed by the primitives packed two per 16-bit word.

Top module: `calo_tpg`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0. Reset sets the delay to 1, the phase to 0, every lookup entry to 0, the sample history to 0, and the sub-period and beam counters to 0.
- R2: For a sample a[k] of a channel taken at clock edge k, the pulse height is a[k] − a[k−D], where D is the delay setting. Samples older than reset count as 0.
- R3: When the earlier sample a[k−D] is larger than a[k], the pulse height is 0.
- R4: A configuration write to address 0 loads D from the low 5 bits of cfg_wdata_i, so D ranges from 1 to 31. A write whose low 5 bits are zero is ignored. A new D applies from the edge after the write.
- R5: A configuration write with cfg_addr_i[10] set stores cfg_wdata_i in lookup entry cfg_addr_i[9:0]. The entry is addressed by height bits [13:4], and the energy is registered one edge after the height. A write takes effect from the next edge; a read on the same edge sees the old content.
- R6: Tower t sums the energies of channels 4t to 4t+3 as a 12-bit value. Its primitive is bits [11:4] of that sum, so four full-scale energies of 1023 give 255.
- R7: At each edge where the sub-period count equals the phase setting, a frame starts. On that edge, valid_o goes high with header {mod_id_i in [15:8], beam count in [7:0]}. The next NUM_TOWERS/2 edges each carry one word w, with tower 2w in bits [7:0] and tower 2w+1 in bits [15:8]. The primitives in the frame come from the samples taken three edges before the header edge.
- R8: A configuration write to address 1 sets the phase when cfg_wdata_i is 0 to 11. Writes of 12 or more are ignored.
- R9: The sub-period count runs 0 to 11 and wraps. The beam count increments, modulo 256, on each edge where the sub-period count wraps.
- R10: Outside a frame, valid_o is 0 and data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adc_i | input | 4*NUM_TOWERS*14 | ADC samples, channel c in bits [14c+13:14c] |
| mod_id_i | input | 8 | Module number placed in the header |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 11 | Configuration address: bit 10 selects the lookup memory, 0 is delay, 1 is phase |
| cfg_wdata_i | input | 10 | Configuration write data |
| valid_o | output | 1 | Frame word valid |
| data_o | output | 16 | Header or packed primitive word |

## Verification
Two corner cases are hard to reach from the ports. The first is the top of the primitive range, which needs all four channels of a tower to produce the largest height on the same edge. The bench gets there by holding the delay at 1 and toggling every channel between 0 and full scale, with entry 1023 loaded to 1023. The second is the 8-bit beam count rollover, which only appears after 256 beam periods, so a long quiet run follows the directed sections. Phase and delay rewrites land while a frame is being sent. Lookup rewrites arrive while samples flow, so that the read-before-write ordering on the same edge is exercised.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int ADC_W   = 14;
  localparam int LUT_AW  = 10;
  localparam int LUT_DW  = 10;
  localparam int SUM_W   = LUT_DW + 2;
  localparam int PRIM_W  = 8;
  localparam int OUT_W   = 2 * PRIM_W;
  localparam int NUM_SUB = 12;
  localparam int PH_W    = 4;
  localparam int BC_W    = 8;
  localparam int MOD_W   = OUT_W - BC_W;
  localparam int CFG_AW  = LUT_AW + 1;
  localparam int CFG_DW  = LUT_DW;

  localparam logic [CFG_AW-1:0] CFG_DELAY = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] CFG_PHASE = CFG_AW'(1);

  typedef logic [ADC_W-1:0]  adc_t;
  typedef logic [LUT_DW-1:0] energy_t;
  typedef logic [PRIM_W-1:0] prim_t;
  typedef logic [OUT_W-1:0]  word_t;
endpackage

// File: rtl/tpg_ped_sub.sv
module tpg_ped_sub import tpg_pkg::*; #(
  parameter int DLY_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  adc_t              adc_i,
  input  logic [DLY_AW-1:0] dly_i,
  output adc_t              diff_o
);
  localparam int DEPTH = 1 << DLY_AW;

  adc_t              hist_q [DEPTH];
  logic [DLY_AW-1:0] wptr_q;
  logic [DLY_AW-1:0] rptr;
  adc_t              ped;

  // slot wptr_q holds the oldest sample; delays stay below DEPTH
  assign rptr = wptr_q - dly_i;
  assign ped  = hist_q[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      wptr_q <= '0;
      diff_o <= '0;
    end else begin
      hist_q[wptr_q] <= adc_i;
      wptr_q         <= wptr_q + 1'b1;
      diff_o         <= (adc_i > ped) ? adc_i - ped : '0;
    end
  end
endmodule

// File: rtl/tpg_lut.sv
module tpg_lut import tpg_pkg::*; #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LUT_AW-1:0] waddr_i,
  input  energy_t           wdata_i,
  input  adc_t              diff_i   [NUM_CH],
  output energy_t           energy_o [NUM_CH]
);
  localparam int ENTRIES = 1 << LUT_AW;

  energy_t mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) energy_o[c] <= '0;
      else         energy_o[c] <= mem_q[diff_i[c][ADC_W-1 -: LUT_AW]];
    end
  end
endmodule

// File: rtl/tpg_tower_sum.sv
module tpg_tower_sum import tpg_pkg::*; #(
  parameter int NUM_TOWERS = 4,
  localparam int NUM_CH = 4 * NUM_TOWERS
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  energy_t energy_i [NUM_CH],
  output prim_t   prim_o   [NUM_TOWERS]
);
  for (genvar t = 0; t < NUM_TOWERS; t++) begin : g_twr
    logic [SUM_W-1:0] sum_c;
    assign sum_c = SUM_W'(energy_i[4*t])   + SUM_W'(energy_i[4*t+1])
                 + SUM_W'(energy_i[4*t+2]) + SUM_W'(energy_i[4*t+3]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prim_o[t] <= '0;
      else         prim_o[t] <= sum_c[SUM_W-1 -: PRIM_W];
    end
  end
endmodule

// File: rtl/tpg_timebase.sv
module tpg_timebase import tpg_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] sub_o,
  output logic [BC_W-1:0] bc_o
);
  localparam logic [PH_W-1:0] SUB_LAST = PH_W'(NUM_SUB - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_o <= '0;
      bc_o  <= '0;
    end else if (sub_o == SUB_LAST) begin
      sub_o <= '0;
      bc_o  <= bc_o + 1'b1;
    end else begin
      sub_o <= sub_o + 1'b1;
    end
  end
endmodule

// File: rtl/tpg_framer.sv
module tpg_framer import tpg_pkg::*; #(
  parameter int NUM_TOWERS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  prim_t            prim_i [NUM_TOWERS],
  input  logic [PH_W-1:0]  sub_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [BC_W-1:0]  bc_i,
  input  logic [MOD_W-1:0] mod_id_i,
  output logic             valid_o,
  output word_t            data_o
);
  localparam int NW   = NUM_TOWERS / 2;
  localparam int WI_W = (NW > 1) ? $clog2(NW) : 1;

  word_t           pair_c [NW];
  word_t           snap_q [NW];
  logic [WI_W-1:0] widx_q;
  logic            busy_q;

  for (genvar w = 0; w < NW; w++) begin : g_pair
    assign pair_c[w] = {prim_i[2*w+1], prim_i[2*w]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) snap_q[w] <= '0;
      widx_q  <= '0;
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (sub_i == phase_i) begin
      snap_q  <= pair_c;
      widx_q  <= '0;
      busy_q  <= 1'b1;
      valid_o <= 1'b1;
      data_o  <= {mod_id_i, bc_i};
    end else if (busy_q) begin
      valid_o <= 1'b1;
      data_o  <= snap_q[widx_q];
      if (widx_q == WI_W'(NW - 1)) busy_q <= 1'b0;
      else                         widx_q <= widx_q + 1'b1;
    end else begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end
  end
endmodule

// File: rtl/calo_tpg.sv
module calo_tpg import tpg_pkg::*; #(
  parameter int NUM_TOWERS = 4,
  parameter int DLY_AW     = 5,
  localparam int NUM_CH    = 4 * NUM_TOWERS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*ADC_W-1:0] adc_i,
  input  logic [MOD_W-1:0]        mod_id_i,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [CFG_DW-1:0]       cfg_wdata_i,
  output logic                    valid_o,
  output logic [OUT_W-1:0]        data_o
);
  logic [DLY_AW-1:0] dly_q;
  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   sub_cnt;
  logic [BC_W-1:0]   bc_cnt;
  logic              lut_we;
  logic              reg_sel;
  adc_t              diff   [NUM_CH];
  energy_t           energy [NUM_CH];
  prim_t             prim   [NUM_TOWERS];

  assign lut_we  = cfg_we_i & cfg_addr_i[CFG_AW-1];
  assign reg_sel = cfg_we_i & ~cfg_addr_i[CFG_AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= DLY_AW'(1);
      phase_q <= '0;
    end else if (reg_sel) begin
      if (cfg_addr_i == CFG_DELAY && cfg_wdata_i[DLY_AW-1:0] != '0)
        dly_q <= cfg_wdata_i[DLY_AW-1:0];
      if (cfg_addr_i == CFG_PHASE && cfg_wdata_i < CFG_DW'(NUM_SUB))
        phase_q <= cfg_wdata_i[PH_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tpg_ped_sub #(.DLY_AW(DLY_AW)) u_ped (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adc_i  (adc_i[c*ADC_W +: ADC_W]),
      .dly_i  (dly_q),
      .diff_o (diff[c])
    );
  end

  tpg_lut #(.NUM_CH(NUM_CH)) u_lut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (lut_we),
    .waddr_i  (cfg_addr_i[LUT_AW-1:0]),
    .wdata_i  (cfg_wdata_i),
    .diff_i   (diff),
    .energy_o (energy)
  );

  tpg_tower_sum #(.NUM_TOWERS(NUM_TOWERS)) u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .energy_i (energy),
    .prim_o   (prim)
  );

  tpg_timebase u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sub_o  (sub_cnt),
    .bc_o   (bc_cnt)
  );

  tpg_framer #(.NUM_TOWERS(NUM_TOWERS)) u_frm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prim_i   (prim),
    .sub_i    (sub_cnt),
    .phase_i  (phase_q),
    .bc_i     (bc_cnt),
    .mod_id_i (mod_id_i),
    .valid_o  (valid_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/calo_tpg_chk.sv
module calo_tpg_chk import tpg_pkg::*; #(
  parameter int DLY_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic [OUT_W-1:0]  data_o,
  input logic [DLY_AW-1:0] dly_q,
  input logic [PH_W-1:0]   phase_q,
  input logic [PH_W-1:0]   sub_cnt,
  input logic [BC_W-1:0]   bc_cnt
);
  localparam logic [PH_W-1:0] SUB_LAST = PH_W'(NUM_SUB - 1);

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0); // R10
  AST_DLY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_q != '0); // R4
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= SUB_LAST); // R8
  AST_SUB_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_cnt == SUB_LAST |=> sub_cnt == '0 && bc_cnt == $past(bc_cnt) + BC_W'(1)); // R9
  AST_BC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_cnt != SUB_LAST |=> $stable(bc_cnt)); // R9
  AST_HDR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_cnt == phase_q |=> valid_o && data_o[BC_W-1:0] == $past(bc_cnt)); // R7
endmodule

bind calo_tpg calo_tpg_chk #(.DLY_AW(DLY_AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .data_o  (data_o),
  .dly_q   (dly_q),
  .phase_q (phase_q),
  .sub_cnt (sub_cnt),
  .bc_cnt  (bc_cnt)
);

// File: tb/sim_calo_tpg.sv
module sim_calo_tpg;
  localparam int CLK_PERIOD = 10;
  localparam int NT  = 4;
  localparam int NCH = 4 * NT;
  localparam int AW  = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH*AW-1:0] adc = '0;
  logic [7:0]     mod_id = 8'hA5;
  logic           cfg_we = 1'b0;
  logic [10:0]    cfg_addr = '0;
  logic [9:0]     cfg_wdata = '0;
  logic           valid;
  logic [15:0]    data;

  int n_checks = 0;
  int n_err = 0;
  string req_tag = "R1";
  int mode = 0;
  int dn = 16000;
  bit tg = 1'b0;

  calo_tpg #(.NUM_TOWERS(NT), .DLY_AW(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .adc_i(adc), .mod_id_i(mod_id),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .valid_o(valid), .data_o(data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_hist [NCH][$];
  int m_diff [NCH];
  int m_en   [NCH];
  int m_prim [NT];
  int m_snap [NT];
  int m_lut  [1024];
  int m_dly, m_phase, m_sub, m_bc, m_widx, m_data;
  bit m_busy, m_valid;
  int nd [NCH];
  int ne [NCH];
  int np [NT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_hist[c].delete();
        repeat (31) m_hist[c].push_back(0);
        m_diff[c] = 0; m_en[c] = 0;
      end
      for (int t = 0; t < NT; t++) begin m_prim[t] = 0; m_snap[t] = 0; end
      for (int i = 0; i < 1024; i++) m_lut[i] = 0;
      m_dly = 1; m_phase = 0; m_sub = 0; m_bc = 0; m_widx = 0;
      m_data = 0; m_busy = 0; m_valid = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int a, p;
        a = int'(adc[c*AW +: AW]);
        p = m_hist[c][m_dly-1];
        nd[c] = (a > p) ? a - p : 0;
        ne[c] = m_lut[m_diff[c] / 16];
      end
      for (int t = 0; t < NT; t++)
        np[t] = (m_en[4*t] + m_en[4*t+1] + m_en[4*t+2] + m_en[4*t+3]) / 16;
      if (m_sub == m_phase) begin
        for (int t = 0; t < NT; t++) m_snap[t] = m_prim[t];
        m_widx = 0; m_busy = 1; m_valid = 1;
        m_data = int'(mod_id) * 256 + m_bc;
      end else if (m_busy) begin
        m_valid = 1;
        m_data = m_snap[2*m_widx] + 256 * m_snap[2*m_widx+1];
        if (m_widx == NT/2 - 1) m_busy = 0; else m_widx++;
      end else begin
        m_valid = 0; m_data = 0;
      end
      if (m_sub == 11) begin m_sub = 0; m_bc = (m_bc + 1) % 256; end
      else m_sub++;
      if (cfg_we) begin
        if (cfg_addr[10]) m_lut[cfg_addr[9:0]] = int'(cfg_wdata);
        else if (cfg_addr == 0 && (cfg_wdata % 32) != 0) m_dly = cfg_wdata % 32;
        else if (cfg_addr == 1 && cfg_wdata < 12) m_phase = int'(cfg_wdata);
      end
      for (int c = 0; c < NCH; c++) begin
        m_hist[c].push_front(int'(adc[c*AW +: AW]));
        void'(m_hist[c].pop_back());
        m_diff[c] = nd[c]; m_en[c] = ne[c];
      end
      for (int t = 0; t < NT; t++) m_prim[t] = np[t];
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    n_checks++;
    if (!rst_n) begin
      if (valid !== 1'b0 || data !== 16'h0) begin
        n_err++;
        $display("FAIL R1: valid %b data %h expected valid 0 data 0000", valid, data);
      end
    end else if (valid !== m_valid || data !== 16'(m_data)) begin
      n_err++;
      $display("FAIL %s: valid %b data %h expected valid %b data %h",
               req_tag, valid, data, m_valid, 16'(m_data));
    end
  end

  // sample driver
  initial begin
    forever begin
      @(posedge clk); #2;
      tg = ~tg;
      dn = dn - 37;
      for (int c = 0; c < NCH; c++) begin
        case (mode)
          1: adc[c*AW +: AW] = AW'(dn - c*5);
          2: adc[c*AW +: AW] = tg ? 14'h3FFF : 14'h0;
          default: adc[c*AW +: AW] = AW'($urandom);
        endcase
      end
    end
  end

  task automatic cfg_wr(input int addr, input int wd);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = 11'(addr); cfg_wdata = 10'(wd);
  endtask

  task automatic cfg_idle();
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    req_tag = "R1";
    #(CLK_PERIOD * 3 + CLK_PERIOD / 2 + 1);
    rst_n = 1'b1;
    req_tag = "R7";                       // R7, R9, R10 framing from reset
    cycles(40);
    mod_id = 8'h3C;
    cycles(30);

    req_tag = "R5";                       // R5 full lookup load while samples flow
    for (int i = 0; i < 1024; i++) cfg_wr(1024 + i, (i * 37 + 11) % 1024);
    cfg_wr(1024 + 1023, 1023);
    cfg_idle();
    cycles(40);

    req_tag = "R2";                       // R2 pedestal with delay 5
    cfg_wr(0, 5); cfg_idle();
    cycles(100);

    req_tag = "R3";                       // R3 falling samples clamp to zero
    dn = 16000; mode = 1;
    cycles(60);
    mode = 0;

    req_tag = "R4";                       // R4 zero low bits ignored, then 31 and 33
    cfg_wr(0, 0); cfg_wr(0, 32); cfg_idle();
    cycles(50);
    cfg_wr(0, 31); cfg_idle();
    cycles(60);
    cfg_wr(0, 33); cfg_idle();
    cycles(40);

    req_tag = "R6";                       // R6 full-scale towers reach 255
    mode = 2;
    cycles(48);
    mode = 0;

    req_tag = "R8";                       // R8 phase moves, out-of-range ignored
    cfg_wr(1, 7); cfg_idle();
    cycles(30);
    cfg_wr(1, 12); cfg_idle();
    cycles(30);
    cfg_wr(1, 15); cfg_wr(1, 11); cfg_idle();
    cycles(30);
    cfg_wr(1, 3); cfg_idle();
    cycles(30);

    req_tag = "R5";                       // R5 rewrites during traffic
    for (int i = 0; i < 64; i++) cfg_wr(1024 + i * 16, i * 16 + 1);
    cfg_idle();
    cycles(40);

    req_tag = "R9";                       // R9 beam count rollover
    cycles(3200);

    finish_run();
  end
endmodule